// File: doc/BRIEF.md
# Arithmetic Flag Unit with Condition Evaluator

This block adds or subtracts two operands of byte, word or long size and derives the sign, zero, half-carry, overflow, subtract and carry flags from the result. It holds those six flags in a small flag register. The add-with-carry and subtract-with-borrow operations take their carry-in from the stored carry. A parity operation reuses the overflow flag to report even parity of a byte or word operand. Each flag has its own write enable, so an operation updates only the flags it defines and the rest keep their value.

A 4-bit condition evaluator reads the stored flags and returns a take/skip decision. The control logic uses it for conditional branches and conditional sets. The arithmetic result is combinational. The flags change at the clock edge on which `valid_i` is high.

Top module: `alu_flag_unit`

## Requirements
- R1: After reset `flags_o` is all zero. The flag bit positions are C=0, N=1, V=2, H=3, Z=4, S=5.
- R2: `op_i` codes are 0 add, 1 add with carry, 2 subtract (`a_i - b_i`), 3 subtract with borrow, 4 parity; codes 5 to 7 are reserved. `size_i` codes are 0 byte (8 bits), 1 word (16 bits), 2 long (32 bits); code 3 behaves as long. `result_o` is the sum or difference truncated to the operand size and zero-extended to 32 bits, and it is zero for reserved codes.
- R3: Add with carry and subtract with borrow use the stored C flag as carry-in or borrow-in. Plain add and subtract use a carry-in of zero.
- R4: After an arithmetic operation, S equals the top bit of the truncated result, and Z is 1 exactly when the truncated result is zero.
- R5: For byte and word operations, H is the carry or borrow out of bit 3, with the carry-in included. A long operation leaves H unchanged.
- R6: For addition, V is 1 when both operands have the same sign and the result sign differs from it. For subtraction, V is 1 when the operand signs differ and the result sign differs from the sign of `a_i`.
- R7: N is cleared by add and add with carry and set by subtract and subtract with borrow. C is the carry out of, or the borrow from, the full operand width.
- R8: The parity operation on a byte or word sets V to 1 when the operand has an even number of one bits, and leaves every other flag unchanged. Its `result_o` is `a_i` truncated to the operand size. On a long operand it changes no flag.
- R9: When `valid_i` is low or `op_i` is reserved, the flags keep their value.
- R10: `take_o` follows `cc_i` against the stored flags. The low three bits select one condition: 0 false, 1 S^V, 2 Z|(S^V), 3 C|Z, 4 V, 5 S, 6 Z, 7 C. Bit 3 inverts the selected condition, so code 8 is always true.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Commit the computed flags at this edge |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Operand size code |
| a_i | input | 32 | Destination operand |
| b_i | input | 32 | Source operand |
| cc_i | input | 4 | Condition code to evaluate |
| result_o | output | 32 | Truncated, zero-extended result |
| flags_o | output | 6 | Stored flags {S,Z,H,V,N,C} |
| take_o | output | 1 | Condition outcome on the stored flags |

## Verification
Any wrong bit in the flag register is visible on `flags_o` one cycle after the edge that wrote it. It also shows up later in two other places. A wrong carry changes the `result_o` of the next add with carry or subtract with borrow in that same cycle. A wrong S, Z, V or C flips `take_o` for any condition that reads it. A write enable that fires when it should not shows up as a flag that changes after a long, parity, idle or reserved operation. The bench keeps its own model of the flags so that such a change is caught on the edge where it happens.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int NFLAG = 6;
  localparam int FL_C = 0;
  localparam int FL_N = 1;
  localparam int FL_V = 2;
  localparam int FL_H = 3;
  localparam int FL_Z = 4;
  localparam int FL_S = 5;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_PAR = 3'd4
  } alu_op_e;
endpackage

// File: rtl/alu_add_lanes.sv
module alu_add_lanes #(
  parameter int DW = 32
) (
  input  logic          sub_i,
  input  logic          cin_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o,
  output logic          s_o,
  output logic          z_o,
  output logic          h_o,
  output logic          v_o,
  output logic          c_o
);
  localparam int NLANE = $clog2(DW / 8) + 1;

  logic [DW-1:0] lane_res [NLANE];
  logic          lane_s   [NLANE];
  logic          lane_h   [NLANE];
  logic          lane_v   [NLANE];
  logic          lane_c   [NLANE];

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    localparam int LW = 8 << k;
    logic [LW:0] ext;
    logic [4:0]  nib;
    logic        a_msb, b_msb, r_msb;

    always_comb begin
      if (sub_i) begin
        ext = {1'b0, a_i[LW-1:0]} - {1'b0, b_i[LW-1:0]} - {{LW{1'b0}}, cin_i};
        nib = {1'b0, a_i[3:0]} - {1'b0, b_i[3:0]} - {4'd0, cin_i};
      end else begin
        ext = {1'b0, a_i[LW-1:0]} + {1'b0, b_i[LW-1:0]} + {{LW{1'b0}}, cin_i};
        nib = {1'b0, a_i[3:0]} + {1'b0, b_i[3:0]} + {4'd0, cin_i};
      end
    end

    assign a_msb       = a_i[LW-1];
    assign b_msb       = b_i[LW-1];
    assign r_msb       = ext[LW-1];
    assign lane_res[k] = DW'(ext[LW-1:0]);
    assign lane_s[k]   = r_msb;
    assign lane_h[k]   = nib[4];
    assign lane_c[k]   = ext[LW];
    // add: equal operand signs flip; sub: differing signs, result leaves dst sign
    assign lane_v[k]   = (sub_i ? (a_msb != b_msb) : (a_msb == b_msb)) && (r_msb != a_msb);
  end

  logic [1:0] sel;
  assign sel = (int'(size_i) >= NLANE - 1) ? 2'(NLANE - 1) : size_i;

  assign res_o = lane_res[sel];
  assign s_o   = lane_s[sel];
  assign z_o   = (lane_res[sel] == '0);
  assign h_o   = lane_h[sel];
  assign v_o   = lane_v[sel];
  assign c_o   = lane_c[sel];
endmodule

// File: rtl/alu_parity.sv
module alu_parity #(
  parameter int DW = 32
) (
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] a_i,
  output logic [DW-1:0] val_o,
  output logic          even_o
);
  localparam int NLANE = $clog2(DW / 8) + 1;

  logic [DW-1:0] lane_val  [NLANE];
  logic          lane_even [NLANE];

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    localparam int LW = 8 << k;
    assign lane_val[k]  = DW'(a_i[LW-1:0]);
    assign lane_even[k] = ~^a_i[LW-1:0];
  end

  logic [1:0] sel;
  assign sel    = (int'(size_i) >= NLANE - 1) ? 2'(NLANE - 1) : size_i;
  assign val_o  = lane_val[sel];
  assign even_o = lane_even[sel];
endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
  import alu_flag_pkg::*;
(
  input  logic [3:0]       cc_i,
  input  logic [NFLAG-1:0] flags_i,
  output logic             take_o
);
  logic s, z, v, c, base;
  assign s = flags_i[FL_S];
  assign z = flags_i[FL_Z];
  assign v = flags_i[FL_V];
  assign c = flags_i[FL_C];

  always_comb begin
    unique case (cc_i[2:0])
      3'd0:    base = 1'b0;
      3'd1:    base = s ^ v;
      3'd2:    base = z | (s ^ v);
      3'd3:    base = c | z;
      3'd4:    base = v;
      3'd5:    base = s;
      3'd6:    base = z;
      default: base = c;
    endcase
  end

  assign take_o = base ^ cc_i[3];
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic [1:0]       size_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  input  logic [3:0]       cc_i,
  output logic [DW-1:0]    result_o,
  output logic [NFLAG-1:0] flags_o,
  output logic             take_o
);
  logic [NFLAG-1:0] flag_q, nf, we;
  logic is_arith, is_par, is_long, cin;
  logic [DW-1:0] add_res, par_val;
  logic s, z, h, v, c, even;

  assign is_arith = ~op_i[2];
  assign is_par   = (op_i == OP_PAR);
  assign is_long  = size_i[1];
  assign cin      = flag_q[FL_C] & op_i[0];

  alu_add_lanes #(.DW(DW)) u_add (
    .sub_i(op_i[1]), .cin_i(cin), .size_i(size_i), .a_i(a_i), .b_i(b_i),
    .res_o(add_res), .s_o(s), .z_o(z), .h_o(h), .v_o(v), .c_o(c)
  );

  alu_parity #(.DW(DW)) u_par (
    .size_i(size_i), .a_i(a_i), .val_o(par_val), .even_o(even)
  );

  alu_cond_eval u_cc (
    .cc_i(cc_i), .flags_i(flag_q), .take_o(take_o)
  );

  always_comb begin
    nf        = '0;
    nf[FL_S]  = s;
    nf[FL_Z]  = z;
    nf[FL_H]  = h;
    nf[FL_V]  = is_par ? even : v;
    nf[FL_N]  = op_i[1];
    nf[FL_C]  = c;
    we        = '0;
    if (is_arith) begin
      we       = '1;
      we[FL_H] = ~is_long;
    end else if (is_par) begin
      we[FL_V] = ~is_long;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= '0;
    else if (valid_i) flag_q <= (nf & we) | (flag_q & ~we);
  end

  assign result_o = is_arith ? add_res : (is_par ? par_val : '0);
  assign flags_o  = flag_q;
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk
  import alu_flag_pkg::*;
#(
  parameter int DW = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [2:0]       op_i,
  input logic [1:0]       size_i,
  input logic [DW-1:0]    a_i,
  input logic [DW-1:0]    b_i,
  input logic [3:0]       cc_i,
  input logic [DW-1:0]    result_o,
  input logic [NFLAG-1:0] flags_o,
  input logic             take_o
);
  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || op_i > 3'd4) |=> $stable(flags_o));

  p_long_h_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i[1]) |=> flags_o[FL_H] == $past(flags_o[FL_H]));

  p_n_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_i[2]) |=> flags_o[FL_N] == $past(op_i[1]));

  p_zero_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_i[2]) |=> flags_o[FL_Z] == ($past(result_o) == '0));

  p_par_only_v_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4) |=>
      ((flags_o & ~(6'b1 << FL_V)) == ($past(flags_o) & ~(6'b1 << FL_V))));

  p_cc_never_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_i == 4'd0) |-> !take_o);

  p_cc_always_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_i == 4'd8) |-> take_o);
endmodule

bind alu_flag_unit alu_flag_unit_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .size_i(size_i), .a_i(a_i), .b_i(b_i), .cc_i(cc_i),
  .result_o(result_o), .flags_o(flags_o), .take_o(take_o)
);

// File: tb/alu_flag_unit_tb.sv
`timescale 1ns/1ps
module alu_flag_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  size = '0;
  logic [31:0] a = '0, b = '0;
  logic [3:0]  cc = '0;
  logic [31:0] result;
  logic [5:0]  flags;
  logic        take;

  always #2 clk = ~clk;

  alu_flag_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .size_i(size),
    .a_i(a), .b_i(b), .cc_i(cc), .result_o(result), .flags_o(flags), .take_o(take)
  );

  typedef struct {
    string       tag;
    logic [31:0] res;
    logic [5:0]  fl;
    logic        tk;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  logic [5:0] mflags = '0;

  // flag bits: C0 N1 V2 H3 Z4 S5
  function automatic logic [31:0] model(input logic [2:0] o, input logic [1:0] sz,
      input logic [31:0] x, input logic [31:0] y, input logic [5:0] fi,
      output logic [5:0] fo);
    int w;
    longint mask, xm, ym, full, nibf, res;
    int cin, ones;
    logic sx, sy, sr;
    w    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    mask = (64'sd1 <<< w) - 1;
    xm   = longint'(x) & mask;
    ym   = longint'(y) & mask;
    fo   = fi;
    if (o > 3'd4) return 32'd0;
    if (o == 3'd4) begin
      ones = $countones(xm);
      if (w != 32) fo[2] = (ones % 2 == 0);
      return 32'(xm);
    end
    cin = (o == 3'd1 || o == 3'd3) ? int'(fi[0]) : 0;
    if (o >= 3'd2) begin
      full = xm - ym - cin;
      nibf = (xm & 15) - (ym & 15) - cin;
      fo[0] = full < 0;
      fo[3] = (w != 32) ? (nibf < 0) : fi[3];
      fo[1] = 1'b1;
    end else begin
      full = xm + ym + cin;
      nibf = (xm & 15) + (ym & 15) + cin;
      fo[0] = full > mask;
      fo[3] = (w != 32) ? (nibf > 15) : fi[3];
      fo[1] = 1'b0;
    end
    res = full & mask;
    sx = xm[w-1]; sy = ym[w-1]; sr = res[w-1];
    fo[5] = sr;
    fo[4] = (res == 0);
    if (o >= 3'd2) fo[2] = (sx != sy) && (sr != sx);
    else           fo[2] = (sx == sy) && (sr != sx);
    return 32'(res);
  endfunction

  function automatic logic cond(input logic [3:0] c, input logic [5:0] f);
    logic bse;
    case (c[2:0])
      3'd0: bse = 1'b0;
      3'd1: bse = f[5] ^ f[2];
      3'd2: bse = f[4] | (f[5] ^ f[2]);
      3'd3: bse = f[0] | f[4];
      3'd4: bse = f[2];
      3'd5: bse = f[5];
      3'd6: bse = f[4];
      default: bse = f[0];
    endcase
    return bse ^ c[3];
  endfunction

  task automatic drive(input string tag, input logic v, input logic [2:0] o,
      input logic [1:0] sz, input logic [31:0] x, input logic [31:0] y,
      input logic [3:0] c);
    item_t it;
    logic [5:0] nf;
    @(negedge clk);
    valid = v; op = o; size = sz; a = x; b = y; cc = c;
    it.tag = tag;
    it.res = model(o, sz, x, y, mflags, nf);
    if (v) mflags = nf;
    it.fl = mflags;
    it.tk = cond(c, mflags);
    q.push_back(it);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: result sampled before the edge, flags and take after it
  initial begin
    logic [31:0] r;
    item_t it;
    forever begin
      @(negedge clk); #1;
      r = result;
      @(posedge clk); #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        check({it.tag, " result"}, r, it.res);
        check({it.tag, " flags"}, 32'(flags), 32'(it.fl));
        check({it.tag, " take"}, 32'(take), 32'(it.tk));
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset flags", 32'(flags), 32'd0);
    cc = 4'd8; #1;
    check("R10 always at reset", 32'(take), 32'd1);
    cc = 4'd0; #1;
    check("R10 never at reset", 32'(take), 32'd0);
    rst_n = 1'b1;

    drive("R6 byte add overflow",  1, 3'd0, 2'd0, 32'h7F, 32'h01, 4'd4);
    drive("R7 byte add carry zero", 1, 3'd0, 2'd0, 32'hFF, 32'h01, 4'd6);
    drive("R3 byte adc",           1, 3'd1, 2'd0, 32'h10, 32'h20, 4'd7);
    drive("R2 word add",           1, 3'd0, 2'd1, 32'hFFFF8000, 32'h8000, 4'd1);
    drive("R5 byte add half",      1, 3'd0, 2'd0, 32'h08, 32'h08, 4'd3);
    drive("R5 long keeps H",       1, 3'd0, 2'd2, 32'hFFFFFFFF, 32'h1, 4'd11);
    drive("R3 long adc",           1, 3'd1, 2'd2, 32'h0, 32'h0, 4'd14);
    drive("R7 byte sub borrow",    1, 3'd2, 2'd0, 32'h00, 32'h01, 4'd15);
    drive("R3 byte sbc",           1, 3'd3, 2'd0, 32'h10, 32'h0F, 4'd6);
    drive("R6 word sub overflow",  1, 3'd2, 2'd1, 32'h8000, 32'h0001, 4'd12);
    drive("R4 long sub sign",      1, 3'd2, 2'd3, 32'h1, 32'h2, 4'd5);
    drive("R8 byte parity even",   1, 3'd4, 2'd0, 32'h1203, 32'h0, 4'd4);
    drive("R8 word parity odd",    1, 3'd4, 2'd1, 32'h10001, 32'h0, 4'd12);
    drive("R8 long parity none",   1, 3'd4, 2'd2, 32'h3, 32'h0, 4'd4);
    drive("R9 idle hold",          0, 3'd0, 2'd0, 32'hFF, 32'h01, 4'd7);
    drive("R9 reserved op",        1, 3'd6, 2'd0, 32'hFF, 32'h01, 4'd6);
    for (int f = 0; f < 4; f++) begin
      drive("R10 set flags", 1, 3'd2, 2'd0, 32'(f * 64), 32'(f * 97 + 1), 4'd0);
      for (int c = 0; c < 16; c++)
        drive("R10 cond sweep", 0, 3'd0, 2'd0, 32'h0, 32'h0, 4'(c));
    end
    for (int i = 0; i < 400; i++)
      drive("R2 random", ($urandom % 8) != 0, 3'($urandom % 6), 2'($urandom % 4),
            $urandom, (i % 5 == 0) ? 32'h0 : $urandom, 4'($urandom % 16));
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule